// File: doc/BRIEF.md
# Core Write Queue with Load Forwarding

This block holds the stores of one processor core that have not yet reached shared memory. Every store from the core is appended to a small circular queue as an address/data pair, and shared memory is only written when the oldest pending pair is drained. Draining happens in a cycle where the external drain grant is high and the core is not blocked by another core that holds the global lock.

Loads from the core search the queue first. If the queue holds a pending store to the load address, the value from the youngest such store is returned. Otherwise the value on the shared memory read port is returned. Loads are only answered while the core is not blocked.

Three kinds of barrier exist. A full barrier stalls the core until the queue is empty, and the block exposes an empty flag for this purpose, so that lock-taking logic outside the block can gate on it too. The load barrier and the store barrier complete at once and do nothing. Arbitration between cores, lock ownership and the memory array are outside the block. The core presents one request per cycle, and a request completes in the cycle in which `req_ready` is high.

Top module: `sbuf_core`

## Requirements
- R1: A store request (kind code 0) is accepted, with `req_ready` high, exactly when fewer than DEPTH entries are pending. When accepted, it is appended at the tail and never writes memory directly.
- R2: A load request (kind code 1) whose address matches one or more pending entries returns, on `rsp_data` in the same cycle, the data of the most recently appended matching entry.
- R3: A load request with no matching pending entry returns `mem_rd_data`, and `mem_rd_addr` equals `req_addr`.
- R4: `mem_we` is high exactly when `drain_grant` and `not_blocked` are high and the queue is non-empty. In that cycle `mem_waddr` and `mem_wdata` carry the oldest entry, and that entry is removed at the clock edge.
- R5: While `not_blocked` is low, no entry is drained, whatever the state of `drain_grant`.
- R6: A full barrier (kind code 2) has `req_ready` high only when the queue is empty.
- R7: A load barrier (kind code 3) or store barrier (kind code 4) has `req_ready` high at once, even while the core is blocked, and leaves the queue contents unchanged.
- R8: A load is answered (`rsp_valid` high, together with `req_ready`) only while `not_blocked` is high.
- R9: `empty` is high exactly when no entry is pending.
- R10: After reset the queue is empty and no drain takes place.
- R11: A store and a drain in the same cycle both take effect: the head leaves and the new entry joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| not_blocked | input | 1 | High when the global lock is free or is held by this core |
| req_valid | input | 1 | A core request is present |
| req_kind | input | 3 | 0 store, 1 load, 2 full barrier, 3 load barrier, 4 store barrier |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | Store data |
| req_ready | output | 1 | The request completes this cycle |
| rsp_valid | output | 1 | Load data is valid this cycle |
| rsp_data | output | DATA_W | Load result |
| mem_rd_addr | output | ADDR_W | Shared memory read address |
| mem_rd_data | input | DATA_W | Shared memory read data, combinational |
| drain_grant | input | 1 | Permission to write the head entry to memory |
| mem_we | output | 1 | Memory write enable for the head entry |
| mem_waddr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| empty | output | 1 | No entries are pending |

## Verification
The assertions assume that the core holds at most one request per cycle, that `req_kind` only takes the five defined codes, and that `mem_rd_data` follows `mem_rd_addr` within the cycle. The bench draws kinds only from the defined codes. It serves reads from its own memory array through a continuous assignment and updates that array only on `mem_we`. The random phase sets `not_blocked` low in about a fifth of the cycles and keeps addresses in a narrow range, so that loads often hit several pending entries and barriers often meet both blocked and unblocked cores.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic [2:0] {
    K_STORE = 3'd0,
    K_LOAD  = 3'd1,
    K_FULLB = 3'd2,
    K_LDB   = 3'd3,
    K_STB   = 3'd4
  } req_kind_e;
endpackage

// File: rtl/sbuf_queue.sv
module sbuf_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic [PTR_W-1:0]  head_ptr,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] slot_addr [DEPTH],
  output logic [DATA_W-1:0] slot_data [DEPTH]
);
  logic [PTR_W-1:0] tail_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                   input logic up, input logic dn);
    return c + CNT_W'(up) - CNT_W'(dn);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      count    <= '0;
    end else begin
      if (push) tail_ptr <= bump(tail_ptr);
      if (pop)  head_ptr <= bump(head_ptr);
      count <= next_count(count, push, pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr[tail_ptr] <= push_addr;
      slot_data[tail_ptr] <= push_data;
    end
  end

  assign head_addr = slot_addr[head_ptr];
  assign head_data = slot_data[head_ptr];

  a_r1_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CNT_W'(DEPTH)));
  a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
  a_r11_count_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (count == $past(count)));
endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [ADDR_W-1:0] look_addr,
  input  logic [PTR_W-1:0]  head_ptr,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] slot_addr [DEPTH],
  input  logic [DATA_W-1:0] slot_data [DEPTH],
  output logic              hit,
  output logic [DATA_W-1:0] fwd_data
);
  function automatic int slot_of(input logic [PTR_W-1:0] h, input int age);
    return (int'(h) + age) % DEPTH;
  endfunction

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    hit      = 1'b0;
    fwd_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (k < int'(count) && slot_addr[slot_of(head_ptr, k)] == look_addr) begin
        hit      = 1'b1;
        fwd_data = slot_data[slot_of(head_ptr, k)];
      end
    end
  end
endmodule

// File: rtl/sbuf_core.sv
module sbuf_core #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              not_blocked,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              drain_grant,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              empty
);
  import sbuf_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];
  logic [PTR_W-1:0]  head_ptr;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;
  logic              full;
  logic              fwd_hit;
  logic [DATA_W-1:0] fwd_data;
  logic              store_fire;
  logic              drain_fire;
  logic              load_fire;
  req_kind_e         kind;

  assign kind  = req_kind_e'(req_kind);
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  always_comb begin
    unique case (kind)
      K_STORE: req_ready = !full;
      K_LOAD:  req_ready = not_blocked;
      K_FULLB: req_ready = empty;
      default: req_ready = 1'b1;
    endcase
  end

  assign store_fire = req_valid && (kind == K_STORE) && !full;
  assign load_fire  = req_valid && (kind == K_LOAD) && not_blocked;
  assign drain_fire = drain_grant && not_blocked && !empty;

  sbuf_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (store_fire),
    .push_addr (req_addr),
    .push_data (req_data),
    .pop       (drain_fire),
    .head_addr (head_addr),
    .head_data (head_data),
    .head_ptr  (head_ptr),
    .count     (count),
    .slot_addr (slot_addr),
    .slot_data (slot_data)
  );

  sbuf_fwd #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fwd (
    .look_addr (req_addr),
    .head_ptr  (head_ptr),
    .count     (count),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .hit       (fwd_hit),
    .fwd_data  (fwd_data)
  );

  assign mem_rd_addr = req_addr;
  assign rsp_valid   = load_fire;
  assign rsp_data    = fwd_hit ? fwd_data : mem_rd_data;
  assign mem_we      = drain_fire;
  assign mem_waddr   = head_addr;
  assign mem_wdata   = head_data;

  a_r5_drain_needs_unblock: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (not_blocked && drain_grant));
  a_r6_fence_waits_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == K_FULLB && req_ready) |-> empty);
  a_r8_load_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> not_blocked);
  a_r2_hit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> !empty);
  a_r9_empty_after_last_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !store_fire && count == CNT_W'(1)) |=> empty);
endmodule

// File: tb/test_sbuf_core.sv
module test_sbuf_core;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              not_blocked = 1'b1;
  logic              req_valid = 1'b0;
  logic [2:0]        req_kind = 3'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic              req_ready, rsp_valid, mem_we, empty;
  logic [DATA_W-1:0] rsp_data, mem_rd_data, mem_wdata;
  logic [ADDR_W-1:0] mem_rd_addr, mem_waddr;
  logic              drain_grant = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] dmem [2**ADDR_W];
  logic [DATA_W-1:0] mmem [2**ADDR_W];
  logic [ADDR_W-1:0] q_a [DEPTH];
  logic [DATA_W-1:0] q_d [DEPTH];
  int q_n = 0;

  always #4 clk = ~clk;

  sbuf_core #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sbuf_core (
    .clk(clk), .rst_n(rst_n), .not_blocked(not_blocked),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_data(req_data), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .drain_grant(drain_grant), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .empty(empty));

  assign mem_rd_data = dmem[mem_rd_addr];
  always @(posedge clk) if (mem_we) dmem[mem_waddr] <= mem_wdata;

  function automatic logic [DATA_W-1:0] init_val(input int a);
    return DATA_W'(a * 37 + 5);
  endfunction

  function automatic logic exp_ready(input int k, input bit nb, input int n);
    if (k == 0) return n < DEPTH;
    if (k == 1) return nb;
    if (k == 2) return n == 0;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int k, input int a, input int d, input bit g, input bit nb);
    logic [DATA_W-1:0] ev;
    bit hit, drn, er;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'(k); req_addr = ADDR_W'(a);
    req_data = DATA_W'(d); drain_grant = g; not_blocked = nb;
    #1;
    er = exp_ready(k, nb, q_n);
    if (k == 0)      chk("R1 store ready", req_ready, er);
    else if (k == 1) chk("R8 load ready", req_ready, er);
    else if (k == 2) chk("R6 full barrier ready", req_ready, er);
    else             chk("R7 light barrier ready", req_ready, er);
    chk("R8 rsp_valid", rsp_valid, (k == 1) && nb);
    chk("R9 empty", empty, q_n == 0);
    if (k == 1 && nb) begin
      hit = 0; ev = mmem[a];
      for (int i = 0; i < q_n; i++) if (q_a[i] == ADDR_W'(a)) begin hit = 1; ev = q_d[i]; end
      if (hit) chk("R2 forwarded data", rsp_data, ev);
      else begin
        chk("R3 memory data", rsp_data, ev);
        chk("R3 read address", mem_rd_addr, a);
      end
    end
    drn = g && nb && (q_n > 0);
    if (!nb) chk("R5 no drain while blocked", mem_we, 1'b0);
    else     chk("R4 write enable", mem_we, drn);
    if (drn) begin
      chk("R4 drain address", mem_waddr, q_a[0]);
      chk("R4 drain data", mem_wdata, q_d[0]);
      mmem[q_a[0]] = q_d[0];
      for (int i = 0; i < DEPTH - 1; i++) begin q_a[i] = q_a[i+1]; q_d[i] = q_d[i+1]; end
      q_n--;
    end
    if (k == 0 && er) begin
      q_a[q_n] = ADDR_W'(a); q_d[q_n] = DATA_W'(d); q_n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2**ADDR_W; i++) begin dmem[i] = init_val(i); mmem[i] = init_val(i); end
    drain_grant = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    // R10: reset state, grant high but nothing to drain
    chk("R10 empty after reset", empty, 1'b1);
    chk("R10 no drain after reset", mem_we, 1'b0);
    rst_n = 1'b1;

    // R1: fill to full, then a store is back-pressured
    for (int i = 0; i < DEPTH; i++) step(0, 3, 100 + i, 0, 1);
    step(0, 4, 999, 0, 1);
    // R2: several matches, youngest wins
    step(1, 3, 0, 0, 1);
    // R3: miss reads memory
    step(1, 9, 0, 0, 1);
    // R6: full barrier stalls while pending
    step(2, 0, 0, 0, 1);
    // R7: light barriers complete while blocked
    step(3, 0, 0, 0, 0);
    step(4, 0, 0, 0, 0);
    // R5 and R8: blocked core, no drain, no load answer
    step(1, 3, 0, 1, 0);
    // R11: drain and store in the same cycle (one slot freed first)
    step(2, 0, 0, 1, 1);
    step(0, 3, 555, 1, 1);
    step(1, 3, 0, 0, 1);
    // drain everything, then the full barrier completes
    for (int i = 0; i < DEPTH + 2; i++) step(3, 0, 0, 1, 1);
    step(2, 0, 0, 0, 1);
    step(1, 3, 0, 0, 1);

    for (int n = 0; n < 3000; n++) begin
      int r, k;
      r = $urandom_range(0, 99);
      k = (r < 40) ? 0 : (r < 75) ? 1 : (r < 85) ? 2 : (r < 93) ? 3 : 4;
      step(k, $urandom_range(0, 5), $urandom_range(0, 65535),
           $urandom_range(0, 99) < 40, $urandom_range(0, 99) < 80);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule